// File: doc/BRIEF.md
# Banked Scratchpad Request Front End

This block sits between several request ports and a local scratchpad that is split into independent banks. Every port can offer one request per cycle: a read or a write with an address, write data, a tag and a core id. The bank a request targets comes from the lowest address bits. Each bank can take one access per cycle, so when two or more ports target the same bank in the same cycle, the lowest-numbered port gets it. The other ports see ready low, keep their request and retry in the next cycle.

An accepted request reaches its bank in the cycle it is granted. A write changes the storage at that clock edge. A read returns its word one cycle later together with the response. Responses come back on the port that made the request and carry that request's tag and core id. Three running counters record accepted reads, accepted writes and the number of requests turned away by bank conflicts. A parameter controls whether accepted writes are acknowledged.

Top module: `spad_bank_front`

## Requirements
- R1: The bank of a request is address bits [log2(NBANKS)-1:0]. The storage row inside that bank is the next higher bits of the local address.
- R2: With NBANKS = 1 there is no bank decoding. In any cycle only the lowest-indexed valid port sees ready.
- R3: Ports are examined in ascending index order. The lowest-indexed valid request to a bank wins that bank, and at most one port wins each bank per cycle. req_ready[p] is high only for a winning port, and never without req_valid[p].
- R4: A valid request that loses its bank is not accepted (ready low). It stays at its port and is retried in the following cycle. Each cycle, stat_stalls grows by the number of valid requests refused that cycle.
- R5: An accepted request raises rsp_valid on the same port index in the next cycle, carrying its tag and core id. Reads always get a response. Writes get one only when WR_RSP = 1.
- R6: A write updates storage at the edge where it is accepted. A read returns the stored word on rsp_rdata in the cycle its response is valid.
- R7: stat_reads and stat_writes grow by the number of reads and writes accepted in each cycle.
- R8: Only the low log2(LINES) address bits select a storage word. Addresses that differ only above those bits reach the same word.
- R9: A synchronous active-high rst clears all counters and all pending responses, so the cycle after reset shows rsp_valid = 0 and all counters at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | NPORTS | Request present, one bit per port |
| req_ready | output | NPORTS | Request accepted this cycle |
| req_write | input | NPORTS | 1 = write, 0 = read |
| req_addr | input | NPORTS*ADDR_W | Addresses, port p at bits [p*ADDR_W +: ADDR_W] |
| req_wdata | input | NPORTS*DATA_W | Write data per port |
| req_tag | input | NPORTS*TAG_W | Request tags per port |
| req_cid | input | NPORTS*CID_W | Core ids per port |
| rsp_valid | output | NPORTS | Response present, one bit per port |
| rsp_rdata | output | NPORTS*DATA_W | Read data per port |
| rsp_tag | output | NPORTS*TAG_W | Returned tag per port |
| rsp_cid | output | NPORTS*CID_W | Returned core id per port |
| stat_reads | output | CNT_W | Accepted reads |
| stat_writes | output | CNT_W | Accepted writes |
| stat_stalls | output | CNT_W | Requests refused due to bank conflict |

## Verification
The block's results have two timings:
- req_ready is combinational. It is checked in the same cycle the request is driven, one time unit after the falling-edge drive.
- Responses, read data and counters all come from registers loaded at the accepting rising edge. They are sampled at the next falling edge, so each is checked exactly one cycle after acceptance.

In a conflict sequence, the bench removes each winning request only after that falling edge. It then checks both the moving ready bit and the growing stall count, one cycle at a time. A second instance with write acknowledgments disabled and a third with a single bank receive the same stimulus, so the parameter-dependent behaviour is checked in the same cycles.

// File: rtl/spad_pkg.sv
`timescale 1ns/1ps
package spad_pkg;
    // population count of up to 32 request bits
    function automatic logic [5:0] ones32(input logic [31:0] v);
        logic [5:0] n;
        n = '0;
        for (int i = 0; i < 32; i++) n = n + 6'(v[i]);
        return n;
    endfunction
endpackage

// File: rtl/spad_arb.sv
`timescale 1ns/1ps
module spad_arb #(
    parameter int NPORTS = 4,
    parameter int NBANKS = 4,
    parameter int SELW   = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NPORTS-1:0]      valid,
    input  logic [NPORTS*SELW-1:0] bank,
    output logic [NPORTS-1:0]      grant
);
    logic [NBANKS-1:0] taken;
    logic [NPORTS-1:0] hit [NBANKS];

    always_comb begin
        taken = '0;
        grant = '0;
        for (int p = 0; p < NPORTS; p++) begin
            if (valid[p] && !taken[bank[p*SELW +: SELW]]) begin
                grant[p] = 1'b1;
                taken[bank[p*SELW +: SELW]] = 1'b1;
            end
        end
    end

    always_comb begin
        for (int b = 0; b < NBANKS; b++)
            for (int p = 0; p < NPORTS; p++)
                hit[b][p] = (32'(bank[p*SELW +: SELW]) == b);
    end

    for (genvar b = 0; b < NBANKS; b++) begin : g_bank_chk
        // R3
        one_grant_per_bank_chk: assert property (@(posedge clk) disable iff (rst)
            $onehot0(grant & hit[b]));
    end

    // R3
    grant_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (grant & ~valid) == '0);

    // R3
    port0_priority_chk: assert property (@(posedge clk) disable iff (rst)
        valid[0] |-> grant[0]);
endmodule

// File: rtl/spad_bank.sv
`timescale 1ns/1ps
module spad_bank #(
    parameter int ROWS   = 16,
    parameter int DATA_W = 32,
    parameter int ROW_W  = 4
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [ROW_W-1:0]  row,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [ROWS];
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (en && we) mem[row] <= wdata;
        if (en && !we) rdata_q <= mem[row];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/spad_bank_front.sv
`timescale 1ns/1ps
module spad_bank_front #(
    parameter int NPORTS = 4,
    parameter int NBANKS = 4,
    parameter int LINES  = 64,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int TAG_W  = 4,
    parameter int CID_W  = 2,
    parameter int CNT_W  = 16,
    parameter bit WR_RSP = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NPORTS-1:0]        req_valid,
    output logic [NPORTS-1:0]        req_ready,
    input  logic [NPORTS-1:0]        req_write,
    input  logic [NPORTS*ADDR_W-1:0] req_addr,
    input  logic [NPORTS*DATA_W-1:0] req_wdata,
    input  logic [NPORTS*TAG_W-1:0]  req_tag,
    input  logic [NPORTS*CID_W-1:0]  req_cid,
    output logic [NPORTS-1:0]        rsp_valid,
    output logic [NPORTS*DATA_W-1:0] rsp_rdata,
    output logic [NPORTS*TAG_W-1:0]  rsp_tag,
    output logic [NPORTS*CID_W-1:0]  rsp_cid,
    output logic [CNT_W-1:0]         stat_reads,
    output logic [CNT_W-1:0]         stat_writes,
    output logic [CNT_W-1:0]         stat_stalls
);
    import spad_pkg::*;

    localparam int LOC_W    = $clog2(LINES);
    localparam int SEL_BITS = $clog2(NBANKS);
    localparam int SELW     = (SEL_BITS == 0) ? 1 : SEL_BITS;
    localparam int ROWS     = LINES / NBANKS;
    localparam int ROW_W    = (ROWS > 1) ? $clog2(ROWS) : 1;

    typedef struct packed {
        logic [NPORTS-1:0]       vld;
        logic [NPORTS*TAG_W-1:0] tag;
        logic [NPORTS*CID_W-1:0] cid;
        logic [NPORTS*SELW-1:0]  bank;
        logic [CNT_W-1:0]        rd;
        logic [CNT_W-1:0]        wr;
        logic [CNT_W-1:0]        st;
    } state_t;

    state_t st_d, st_q;

    logic [NPORTS*SELW-1:0]  bank_of;
    logic [ROW_W-1:0]        row_of  [NPORTS];
    logic [NPORTS-1:0]       grant;
    logic [NPORTS*ADDR_W-1:0] unused_addr;

    logic              bk_en    [NBANKS];
    logic              bk_we    [NBANKS];
    logic [ROW_W-1:0]  bk_row   [NBANKS];
    logic [DATA_W-1:0] bk_wdata [NBANKS];
    logic [DATA_W-1:0] bk_rdata [NBANKS];

    assign unused_addr = req_addr;

    // address split: bank from the lowest bits, row from the rest of the local address
    for (genvar p = 0; p < NPORTS; p++) begin : g_dec
        logic [LOC_W-1:0] loc;
        assign loc = req_addr[p*ADDR_W +: LOC_W];
        if (SEL_BITS == 0) begin : g_one
            assign bank_of[p*SELW +: SELW] = '0;
        end else begin : g_many
            assign bank_of[p*SELW +: SELW] = loc[SEL_BITS-1:0];
        end
        assign row_of[p] = ROW_W'(loc >> SEL_BITS);
    end

    spad_arb #(.NPORTS(NPORTS), .NBANKS(NBANKS), .SELW(SELW)) u_arb (
        .clk   (clk),
        .rst   (rst),
        .valid (req_valid),
        .bank  (bank_of),
        .grant (grant)
    );

    assign req_ready = grant;

    // route each granted request to its bank
    always_comb begin
        for (int b = 0; b < NBANKS; b++) begin
            bk_en[b]    = 1'b0;
            bk_we[b]    = 1'b0;
            bk_row[b]   = '0;
            bk_wdata[b] = '0;
            for (int p = 0; p < NPORTS; p++) begin
                if (grant[p] && 32'(bank_of[p*SELW +: SELW]) == b) begin
                    bk_en[b]    = 1'b1;
                    bk_we[b]    = req_write[p];
                    bk_row[b]   = row_of[p];
                    bk_wdata[b] = req_wdata[p*DATA_W +: DATA_W];
                end
            end
        end
    end

    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        spad_bank #(.ROWS(ROWS), .DATA_W(DATA_W), .ROW_W(ROW_W)) u_bank (
            .clk   (clk),
            .en    (bk_en[b]),
            .we    (bk_we[b]),
            .row   (bk_row[b]),
            .wdata (bk_wdata[b]),
            .rdata (bk_rdata[b])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = grant & (~req_write | {NPORTS{WR_RSP}});
        for (int p = 0; p < NPORTS; p++) begin
            if (grant[p]) begin
                st_d.tag[p*TAG_W +: TAG_W] = req_tag[p*TAG_W +: TAG_W];
                st_d.cid[p*CID_W +: CID_W] = req_cid[p*CID_W +: CID_W];
                st_d.bank[p*SELW +: SELW]  = bank_of[p*SELW +: SELW];
            end
        end
        st_d.rd = st_q.rd + CNT_W'(ones32(32'(grant & ~req_write)));
        st_d.wr = st_q.wr + CNT_W'(ones32(32'(grant & req_write)));
        st_d.st = st_q.st + CNT_W'(ones32(32'(req_valid & ~grant)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.vld <= '0;
            st_q.rd  <= '0;
            st_q.wr  <= '0;
            st_q.st  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // response data comes from the bank the request used
    for (genvar p = 0; p < NPORTS; p++) begin : g_rsp
        if (NBANKS == 1) begin : g_one
            assign rsp_rdata[p*DATA_W +: DATA_W] = bk_rdata[0];
        end else begin : g_many
            assign rsp_rdata[p*DATA_W +: DATA_W] = bk_rdata[st_q.bank[p*SELW +: SELW]];
        end

        // R5
        rsp_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
            rsp_valid[p] |-> $past(req_valid[p] && req_ready[p]));

        // R5
        rsp_tag_chk: assert property (@(posedge clk) disable iff (rst)
            rsp_valid[p] |-> (rsp_tag[p*TAG_W +: TAG_W] == $past(req_tag[p*TAG_W +: TAG_W])
                             && rsp_cid[p*CID_W +: CID_W] == $past(req_cid[p*CID_W +: CID_W])));

        // R5
        write_ack_gate_chk: assert property (@(posedge clk) disable iff (rst)
            (rsp_valid[p] && !WR_RSP) |-> !$past(req_write[p]));
    end

    assign rsp_valid   = st_q.vld;
    assign rsp_tag     = st_q.tag;
    assign rsp_cid     = st_q.cid;
    assign stat_reads  = st_q.rd;
    assign stat_writes = st_q.wr;
    assign stat_stalls = st_q.st;

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (rsp_valid == '0 && stat_reads == '0 && stat_writes == '0 && stat_stalls == '0));
endmodule

// File: tb/spad_bank_front_tb.sv
`timescale 1ns/1ps
module spad_bank_front_tb;
    localparam int NP = 4, AW = 16, DW = 32, TW = 4, CW = 2, KW = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic          v [NP];
    logic          w [NP];
    logic [AW-1:0] a [NP];
    logic [DW-1:0] d [NP];
    logic [TW-1:0] t [NP];
    logic [CW-1:0] c [NP];

    logic [NP-1:0]    req_valid, req_write;
    logic [NP*AW-1:0] req_addr;
    logic [NP*DW-1:0] req_wdata;
    logic [NP*TW-1:0] req_tag;
    logic [NP*CW-1:0] req_cid;

    always_comb begin
        for (int p = 0; p < NP; p++) begin
            req_valid[p]          = v[p];
            req_write[p]          = w[p];
            req_addr[p*AW +: AW]  = a[p];
            req_wdata[p*DW +: DW] = d[p];
            req_tag[p*TW +: TW]   = t[p];
            req_cid[p*CW +: CW]   = c[p];
        end
    end

    logic [NP-1:0]    rdy, rv, rdy_nr, rv_nr, rdy_one, rv_one;
    logic [NP*DW-1:0] rd, rd_nr, rd_one;
    logic [NP*TW-1:0] rt, rt_nr, rt_one;
    logic [NP*CW-1:0] rc, rc_nr, rc_one;
    logic [KW-1:0]    s_rd, s_wr, s_st, n_rd, n_wr, n_st, o_rd, o_wr, o_st;

    spad_bank_front u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(rdy), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_tag(req_tag), .req_cid(req_cid),
        .rsp_valid(rv), .rsp_rdata(rd), .rsp_tag(rt), .rsp_cid(rc),
        .stat_reads(s_rd), .stat_writes(s_wr), .stat_stalls(s_st));

    spad_bank_front #(.WR_RSP(1'b0)) u_dut_nr (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(rdy_nr), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_tag(req_tag), .req_cid(req_cid),
        .rsp_valid(rv_nr), .rsp_rdata(rd_nr), .rsp_tag(rt_nr), .rsp_cid(rc_nr),
        .stat_reads(n_rd), .stat_writes(n_wr), .stat_stalls(n_st));

    spad_bank_front #(.NBANKS(1)) u_dut_one (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(rdy_one), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_tag(req_tag), .req_cid(req_cid),
        .rsp_valid(rv_one), .rsp_rdata(rd_one), .rsp_tag(rt_one), .rsp_cid(rc_one),
        .stat_reads(o_rd), .stat_writes(o_wr), .stat_stalls(o_st));

    int n_tests = 0, n_fail = 0;
    int e_rd = 0, e_wr = 0, e_st = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        for (int p = 0; p < NP; p++) begin
            v[p] = 1'b0; w[p] = 1'b0; a[p] = '0; d[p] = '0; t[p] = '0; c[p] = '0;
        end
    endtask

    task automatic check_counters(input string req);
        check(s_rd == KW'(e_rd), req, "reads counter", 64'(s_rd), 64'(e_rd));
        check(s_wr == KW'(e_wr), req, "writes counter", 64'(s_wr), 64'(e_wr));
        check(s_st == KW'(e_st), req, "stalls counter", 64'(s_st), 64'(e_st));
    endtask

    task automatic t_reset();
        check(rv == '0, "R9", "rsp_valid after reset", 64'(rv), 0);
        check_counters("R9");
    endtask

    // writes to four distinct banks are all accepted in one cycle
    task automatic t_parallel_write();
        for (int p = 0; p < NP; p++) begin
            v[p] = 1'b1; w[p] = 1'b1; a[p] = AW'(p); d[p] = 32'hA000 + 32'(p);
            t[p] = TW'(p + 1); c[p] = CW'(p);
        end
        #1;
        check(rdy == 4'hF, "R1", "ready, distinct banks", 64'(rdy), 64'hF);
        check(rdy_one == 4'b0001, "R2", "single-bank ready", 64'(rdy_one), 64'h1);
        step();
        idle();
        e_wr += 4;
        check(rv == 4'hF, "R5", "write ack valid", 64'(rv), 64'hF);
        check(rv_nr == 4'h0, "R5", "no write ack when disabled", 64'(rv_nr), 0);
        for (int p = 0; p < NP; p++) begin
            check(rt[p*TW +: TW] == TW'(p + 1), "R5", "returned tag", 64'(rt[p*TW +: TW]), 64'(p + 1));
            check(rc[p*CW +: CW] == CW'(p), "R5", "returned cid", 64'(rc[p*CW +: CW]), 64'(p));
        end
        check_counters("R7");
    endtask

    // read back in reverse bank order
    task automatic t_parallel_read();
        for (int p = 0; p < NP; p++) begin
            v[p] = 1'b1; w[p] = 1'b0; a[p] = AW'(3 - p); t[p] = TW'(p + 5);
        end
        #1;
        check(rdy == 4'hF, "R1", "ready, reverse banks", 64'(rdy), 64'hF);
        step();
        idle();
        e_rd += 4;
        check(rv == 4'hF, "R5", "read rsp valid", 64'(rv), 64'hF);
        check(rv_nr == 4'hF, "R5", "read rsp with acks off", 64'(rv_nr), 64'hF);
        for (int p = 0; p < NP; p++)
            check(rd[p*DW +: DW] == 32'hA000 + 32'(3 - p), "R6", "read data",
                  64'(rd[p*DW +: DW]), 64'(32'hA000 + 32'(3 - p)));
        check_counters("R7");
    endtask

    // every port targets bank 1; winners drain one per cycle
    task automatic t_conflict();
        for (int p = 0; p < NP; p++) begin
            v[p] = 1'b1; w[p] = 1'b1; a[p] = AW'(1 + 4 * p); d[p] = 32'hB000 + 32'(p);
            t[p] = TW'(8 + p);
        end
        for (int k = 0; k < NP; k++) begin
            #1;
            check(rdy == NP'(1 << k), "R4", "conflict ready", 64'(rdy), 64'(1 << k));
            step();
            e_wr += 1;
            e_st += NP - 1 - k;
            v[k] = 1'b0;
            check(rv == NP'(1 << k), "R4", "one rsp per cycle", 64'(rv), 64'(1 << k));
            check(rt[k*TW +: TW] == TW'(8 + k), "R5", "conflict tag", 64'(rt[k*TW +: TW]), 64'(8 + k));
            check(s_st == KW'(e_st), "R4", "stall count", 64'(s_st), 64'(e_st));
        end
        idle();
        v[3] = 1'b1; a[3] = 16'd9;
        step();
        idle();
        e_rd += 1;
        check(rd[3*DW +: DW] == 32'hB002, "R6", "retried write stored", 64'(rd[3*DW +: DW]), 64'hB002);
        check_counters("R4");
    endtask

    // port1 and port2 share bank 2, port3 alone on bank 3
    task automatic t_priority_mix();
        v[1] = 1'b1; a[1] = 16'd2;
        v[2] = 1'b1; a[2] = 16'd6;
        v[3] = 1'b1; a[3] = 16'd3;
        #1;
        check(rdy == 4'b1010, "R3", "lowest index wins bank", 64'(rdy), 64'hA);
        step();
        idle();
        e_rd += 2; e_st += 1;
        check(rv == 4'b1010, "R3", "winners respond", 64'(rv), 64'hA);
        check(rd[1*DW +: DW] == 32'hA002, "R6", "port1 data", 64'(rd[1*DW +: DW]), 64'hA002);
        check(rd[3*DW +: DW] == 32'hA003, "R6", "port3 data", 64'(rd[3*DW +: DW]), 64'hA003);
        check_counters("R4");
    endtask

    // address 76 and 12 share the low 6 bits
    task automatic t_alias();
        v[0] = 1'b1; w[0] = 1'b1; a[0] = 16'd76; d[0] = 32'hCAFE;
        step();
        idle();
        e_wr += 1;
        v[1] = 1'b1; a[1] = 16'h800C;
        step();
        idle();
        e_rd += 1;
        check(rd[1*DW +: DW] == 32'hCAFE, "R8", "high address bits ignored", 64'(rd[1*DW +: DW]), 64'hCAFE);
        check_counters("R8");
    endtask

    task automatic t_reset_clear();
        v[0] = 1'b1; a[0] = 16'd0;
        v[1] = 1'b1; a[1] = 16'd4;
        rst = 1'b1;
        step();
        rst = 1'b0;
        idle();
        e_rd = 0; e_wr = 0; e_st = 0;
        check(rv == '0, "R9", "rsp cleared by reset", 64'(rv), 0);
        check_counters("R9");
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_parallel_write();
        t_parallel_read();
        t_conflict();
        t_priority_mix();
        t_alias();
        t_reset_clear();
        done = 1'b1;
        finish_run();
    end
endmodule